// File: doc/BRIEF.md
# Register alias table with tag wakeup

This block keeps renaming state for a small out-of-order core that is modelled one instruction at a time. It has one entry for each of 256 architectural registers. Each entry holds the tag of the newest in-flight producer of that register and a ready bit. It stores no data values. A dispatched instruction reads the entries of its two source registers and claims its destination register. It is then placed in a small scheduling queue, where each source waits until it sees a matching tag on the completion broadcast.

On completion, the destination entry is marked ready if it still belongs to the completing tag. The tag is broadcast to every waiting source in the queue, and the completing instruction's own queue entry is removed. Stores follow exactly the same path, so a store that also writes a register (a stack-pointer update, for example) wakes its dependents. The code 16'hFFFF (-1) means "no register", and every table operation on it does nothing. A no-progress watchdog watches the core's retired and fetched counts, its occupancy figures and the queue occupancy. It raises a sticky error when none of them has changed for a configurable number of cycles.

Top module: `rename_wakeup`

## Requirements
- R1: After reset, every table entry reads ready with tag 0, no entry is offered for issue, q_full is 0 and stall_err is 0.
- R2: A dispatch that claims register d with tag t makes reads of d return tag t and not-ready from the next cycle on.
- R3: A completion of register d with tag t sets d ready only if d's current tag equals t. A completion with an older tag leaves d not-ready.
- R4: A queue entry is offered on issue_valid/issue_tag only when both of its sources are ready. A source woken by a completion broadcast first allows issue in the cycle after the broadcast.
- R5: Register code 16'hFFFF (-1) reads as ready with tag 0, is never claimed, and a completion naming it changes no table entry, although its tag is still broadcast and its queue entry is still removed.
- R6: A completion with cmp_store=1 behaves exactly like any other completion. If it names a real register, that register becomes ready and waiting dependents wake.
- R7: When a claim and a completion hit the same register in the same cycle, the claim wins: the register holds the new tag and reads not-ready.
- R8: disp_dsts holds DST_SLOTS 8-bit destination slots, with slot 0 in bits [7:0]. A slot value of 0 means empty, and the lowest-numbered nonzero slot is taken as the destination. If all slots are zero, nothing is claimed.
- R9: A new queue entry takes the lowest free slot. When several entries are eligible, the lowest slot is offered first, and each entry is offered in exactly one cycle.
- R10: A completion removes the queue entry whose own tag matches. q_full is 1 when all QDEPTH slots are used, and a dispatch while q_full is 1 is dropped with no claim.
- R11: stall_err rises after STALL_LIMIT consecutive clock edges in which wd_retired, wd_fetched, wd_rob, wd_dispq and the queue occupancy are all unchanged. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch of one instruction this cycle |
| disp_src1 | input | 16 | First source register id (16'hFFFF = none) |
| disp_src2 | input | 16 | Second source register id (16'hFFFF = none) |
| disp_dsts | input | DST_SLOTS*8 | Destination slots, 0 = empty |
| disp_tag | input | TAG_W | Tag of the dispatched instruction |
| src1_tag | output | TAG_W | Table tag for disp_src1 |
| src1_rdy | output | 1 | Table ready bit for disp_src1 |
| src2_tag | output | TAG_W | Table tag for disp_src2 |
| src2_rdy | output | 1 | Table ready bit for disp_src2 |
| q_full | output | 1 | All queue slots in use |
| cmp_valid | input | 1 | Completion this cycle |
| cmp_dst | input | 16 | Completing destination register (16'hFFFF = none) |
| cmp_tag | input | TAG_W | Completing tag, broadcast to the queue |
| cmp_store | input | 1 | Completion is a store |
| issue_valid | output | 1 | An eligible queue entry is selected |
| issue_tag | output | TAG_W | Tag of the selected entry |
| wd_retired | input | CNT_W | Core retired count |
| wd_fetched | input | CNT_W | Core fetched count |
| wd_rob | input | CNT_W | Reorder buffer occupancy |
| wd_dispq | input | CNT_W | Dispatch queue occupancy |
| stall_err | output | 1 | Sticky no-progress error |

## Verification
The bench builds the block with QDEPTH=4, STALL_LIMIT=5 and TAG_W=6. The shallow queue lets it fill every slot and show that a dispatch is dropped while full. The watchdog limit of five edges lets it probe both sides of the threshold and the sticky hold within a few cycles, where the default of a million would be out of reach. The full 256-entry table is kept, so the ids 200 and 255 exercise the top of the range next to the -1 code.

// File: rtl/rename_wakeup.sv
module rename_wakeup #(
  parameter int TAG_W       = 6,
  parameter int QDEPTH      = 8,
  parameter int DST_SLOTS   = 2,
  parameter int CNT_W       = 16,
  parameter int STALL_LIMIT = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [15:0]            disp_src1,
  input  logic [15:0]            disp_src2,
  input  logic [DST_SLOTS*8-1:0] disp_dsts,
  input  logic [TAG_W-1:0]       disp_tag,
  output logic [TAG_W-1:0]       src1_tag,
  output logic                   src1_rdy,
  output logic [TAG_W-1:0]       src2_tag,
  output logic                   src2_rdy,
  output logic                   q_full,
  input  logic                   cmp_valid,
  input  logic [15:0]            cmp_dst,
  input  logic [TAG_W-1:0]       cmp_tag,
  input  logic                   cmp_store,
  output logic                   issue_valid,
  output logic [TAG_W-1:0]       issue_tag,
  input  logic [CNT_W-1:0]       wd_retired,
  input  logic [CNT_W-1:0]       wd_fetched,
  input  logic [CNT_W-1:0]       wd_rob,
  input  logic [CNT_W-1:0]       wd_dispq,
  output logic                   stall_err
);
  localparam int NREG   = 256;
  localparam logic [15:0] NOREG = 16'hFFFF;
  localparam int QIDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int WDC_W  = $clog2(STALL_LIMIT + 1);
  localparam int SIG_W  = 4 * CNT_W + QCNT_W;

  logic [TAG_W-1:0] tbl_tag [NREG];
  logic [NREG-1:0]  tbl_rdy;

  logic [QDEPTH-1:0] q_vld, q_iss, q_r1, q_r2;
  logic [TAG_W-1:0]  q_tag [QDEPTH];
  logic [TAG_W-1:0]  q_t1  [QDEPTH];
  logic [TAG_W-1:0]  q_t2  [QDEPTH];

  logic [15:0]       dst_sel;
  logic [QIDX_W-1:0] free_idx, issue_idx;
  logic [QDEPTH-1:0] elig;

  always_comb begin
    dst_sel = NOREG;
    for (int i = DST_SLOTS - 1; i >= 0; i--)
      if (disp_dsts[i*8 +: 8] != 8'd0) dst_sel = {8'd0, disp_dsts[i*8 +: 8]};
  end

  wire       disp_ok   = disp_valid && !q_full;
  wire       claim_en  = disp_ok && (dst_sel != NOREG);
  wire [7:0] claim_idx = dst_sel[7:0];
  wire       cmp_en    = cmp_valid && (cmp_dst != NOREG);
  wire [7:0] cmp_idx   = cmp_dst[7:0];
  wire       same_reg  = claim_en && cmp_en && (claim_idx == cmp_idx);

  assign src1_rdy = (disp_src1 == NOREG) | tbl_rdy[disp_src1[7:0]];
  assign src1_tag = (disp_src1 == NOREG) ? '0 : tbl_tag[disp_src1[7:0]];
  assign src2_rdy = (disp_src2 == NOREG) | tbl_rdy[disp_src2[7:0]];
  assign src2_tag = (disp_src2 == NOREG) ? '0 : tbl_tag[disp_src2[7:0]];

  wire ins_r1 = src1_rdy | (cmp_valid && cmp_tag == src1_tag);
  wire ins_r2 = src2_rdy | (cmp_valid && cmp_tag == src2_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_rdy <= '1;
      for (int r = 0; r < NREG; r++) tbl_tag[r] <= '0;
    end else begin
      if (cmp_en && tbl_tag[cmp_idx] == cmp_tag) tbl_rdy[cmp_idx] <= 1'b1;
      if (claim_en) begin
        tbl_tag[claim_idx] <= disp_tag;
        tbl_rdy[claim_idx] <= 1'b0;
      end
    end
  end

  assign elig   = q_vld & ~q_iss & q_r1 & q_r2;
  assign q_full = &q_vld;

  always_comb begin
    free_idx  = '0;
    issue_idx = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (!q_vld[i]) free_idx  = QIDX_W'(i);
      if (elig[i])   issue_idx = QIDX_W'(i);
    end
  end

  assign issue_valid = |elig;
  assign issue_tag   = q_tag[issue_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_iss <= '0;
      q_r1  <= '0;
      q_r2  <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_tag[i] <= '0;
        q_t1[i]  <= '0;
        q_t2[i]  <= '0;
      end
    end else begin
      if (issue_valid) q_iss[issue_idx] <= 1'b1;
      for (int i = 0; i < QDEPTH; i++) begin
        if (cmp_valid && q_vld[i]) begin
          if (q_t1[i] == cmp_tag)  q_r1[i]  <= 1'b1;
          if (q_t2[i] == cmp_tag)  q_r2[i]  <= 1'b1;
          if (q_tag[i] == cmp_tag) q_vld[i] <= 1'b0;
        end
      end
      if (disp_ok) begin
        q_vld[free_idx] <= 1'b1;
        q_iss[free_idx] <= 1'b0;
        q_tag[free_idx] <= disp_tag;
        q_t1[free_idx]  <= src1_tag;
        q_t2[free_idx]  <= src2_tag;
        q_r1[free_idx]  <= ins_r1;
        q_r2[free_idx]  <= ins_r2;
      end
    end
  end

  logic [SIG_W-1:0] sig_q;
  logic [WDC_W-1:0] wd_cnt;
  wire  [QCNT_W-1:0] q_occ = QCNT_W'($countones(q_vld));
  wire  [SIG_W-1:0]  sig   = {wd_retired, wd_fetched, wd_rob, wd_dispq, q_occ};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q     <= '0;
      wd_cnt    <= '0;
      stall_err <= 1'b0;
    end else begin
      sig_q <= sig;
      if (sig != sig_q) wd_cnt <= '0;
      else if (wd_cnt != WDC_W'(STALL_LIMIT - 1)) wd_cnt <= wd_cnt + 1'b1;
      else stall_err <= 1'b1;
    end
  end

  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim_en |=> (tbl_tag[$past(claim_idx)] == $past(disp_tag)) && !tbl_rdy[$past(claim_idx)]);

  p_stale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && tbl_tag[cmp_idx] != cmp_tag && !same_reg)
    |=> tbl_rdy[$past(cmp_idx)] == $past(tbl_rdy[cmp_idx]));

  p_store_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_store && tbl_tag[cmp_idx] == cmp_tag && !same_reg)
    |=> tbl_rdy[$past(cmp_idx)]);

  p_claim_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    same_reg |=> !tbl_rdy[$past(cmp_idx)]);

  p_issue_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && issue_tag == $past(issue_tag)));

  p_done_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !(disp_ok && disp_tag == cmp_tag))
    |=> !(issue_valid && issue_tag == $past(cmp_tag)));

  p_stall_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |=> stall_err);
endmodule

// File: tb/tb_rename_wakeup.sv
module tb_rename_wakeup;
  localparam int TAG_W = 6;
  localparam int QDEPTH = 4;
  localparam int DST_SLOTS = 2;
  localparam int CNT_W = 16;
  localparam int STALL_LIMIT = 5;
  localparam logic [15:0] NR = 16'hFFFF;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0;
  logic [15:0] disp_src1 = NR, disp_src2 = NR;
  logic [DST_SLOTS*8-1:0] disp_dsts = '0;
  logic [TAG_W-1:0] disp_tag = '0;
  logic [TAG_W-1:0] src1_tag, src2_tag, issue_tag;
  logic src1_rdy, src2_rdy, q_full, issue_valid, stall_err;
  logic cmp_valid = 0, cmp_store = 0;
  logic [15:0] cmp_dst = NR;
  logic [TAG_W-1:0] cmp_tag = '0;
  logic [CNT_W-1:0] wd_retired = '0, wd_fetched = '0, wd_rob = '0, wd_dispq = '0;
  logic tick_en = 1;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rename_wakeup #(.TAG_W(TAG_W), .QDEPTH(QDEPTH), .DST_SLOTS(DST_SLOTS),
                  .CNT_W(CNT_W), .STALL_LIMIT(STALL_LIMIT)) dut (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] dst;
    logic [5:0]  tag;
    logic [15:0] rd;
    logic [5:0]  etag;
    logic        erdy;
  } vec_t;

  // op: 0 claim via slot 0, 1 complete, 2 store complete, 3 claim via slot 1
  localparam vec_t VEC [12] = '{
    '{2'd0, 16'd5,   6'd3,  16'd5,   6'd3,  1'b0},
    '{2'd1, 16'd5,   6'd3,  16'd5,   6'd3,  1'b1},
    '{2'd0, 16'd5,   6'd4,  16'd5,   6'd4,  1'b0},
    '{2'd1, 16'd5,   6'd3,  16'd5,   6'd4,  1'b0},
    '{2'd2, 16'd5,   6'd4,  16'd5,   6'd4,  1'b1},
    '{2'd0, 16'd200, 6'd7,  16'd200, 6'd7,  1'b0},
    '{2'd2, NR,      6'd7,  16'd200, 6'd7,  1'b0},
    '{2'd1, 16'd200, 6'd7,  16'd200, 6'd7,  1'b1},
    '{2'd0, 16'd255, 6'd9,  16'd255, 6'd9,  1'b0},
    '{2'd2, 16'd255, 6'd9,  16'd255, 6'd9,  1'b1},
    '{2'd3, 16'd12,  6'd11, 16'd12,  6'd11, 1'b0},
    '{2'd1, 16'd12,  6'd11, 16'd12,  6'd11, 1'b1}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    disp_valid = 0; disp_dsts = '0; disp_src1 = NR; disp_src2 = NR;
    cmp_valid = 0; cmp_dst = NR; cmp_store = 0;
  endtask

  task automatic dispatch(input logic [15:0] dsts, input logic [15:0] s1,
                          input logic [15:0] s2, input logic [5:0] tag);
    disp_valid = 1; disp_dsts = dsts; disp_src1 = s1; disp_src2 = s2; disp_tag = tag;
    step();
    idle();
  endtask

  task automatic complete(input logic [15:0] dst, input logic [5:0] tag, input logic st);
    cmp_valid = 1; cmp_dst = dst; cmp_tag = tag; cmp_store = st;
    step();
    idle();
  endtask

  task automatic read_reg(input string req, input logic [15:0] r,
                          input logic [5:0] etag, input logic erdy);
    disp_src1 = r;
    #1;
    chk(req, {26'd0, src1_tag}, {26'd0, etag});
    chk(req, {31'd0, src1_rdy}, {31'd0, erdy});
    disp_src1 = NR;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (tick_en) wd_retired <= wd_retired + 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    read_reg("R1", 16'd5, 6'd0, 1'b1);
    read_reg("R1", 16'd255, 6'd0, 1'b1);
    chk("R1", {31'd0, issue_valid}, 0);
    chk("R1", {31'd0, q_full}, 0);
    chk("R1", {31'd0, stall_err}, 0);
    // R5 no-register read
    read_reg("R5", NR, 6'd0, 1'b1);

    // vector walk: R2 R3 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      case (VEC[i].op)
        2'd0: dispatch({8'd0, VEC[i].dst[7:0]}, NR, NR, VEC[i].tag);
        2'd3: dispatch({VEC[i].dst[7:0], 8'd0}, NR, NR, VEC[i].tag);
        2'd1: complete(VEC[i].dst, VEC[i].tag, 1'b0);
        default: complete(VEC[i].dst, VEC[i].tag, 1'b1);
      endcase
      read_reg($sformatf("R2/R3/R5/R6/R8 vec%0d", i), VEC[i].rd, VEC[i].etag, VEC[i].erdy);
    end

    // R8/R5: all slots empty claims nothing
    dispatch(16'd0, NR, NR, 6'd25);
    read_reg("R8", 16'd12, 6'd11, 1'b1);
    complete(NR, 6'd25, 1'b0);

    // R4 single-source wakeup timing
    dispatch({8'd0, 8'd30}, NR, NR, 6'd1);
    chk("R4", {31'd0, issue_valid}, 1);
    chk("R4", {26'd0, issue_tag}, 1);
    dispatch(16'd0, 16'd30, NR, 6'd2);
    chk("R4", {31'd0, issue_valid}, 0);
    complete(16'd30, 6'd1, 1'b0);
    chk("R4", {31'd0, issue_valid}, 1);
    chk("R4", {26'd0, issue_tag}, 2);
    step();
    chk("R9", {31'd0, issue_valid}, 0);
    complete(NR, 6'd2, 1'b0);

    // R4 both sources needed
    dispatch({8'd0, 8'd40}, NR, NR, 6'd3);
    dispatch({8'd0, 8'd41}, NR, NR, 6'd4);
    dispatch(16'd0, 16'd40, 16'd41, 6'd5);
    chk("R4", {31'd0, issue_valid}, 0);
    complete(16'd40, 6'd3, 1'b0);
    chk("R4", {31'd0, issue_valid}, 0);
    complete(16'd41, 6'd4, 1'b1);
    chk("R4/R6", {31'd0, issue_valid}, 1);
    chk("R4/R6", {26'd0, issue_tag}, 5);
    step();
    complete(NR, 6'd5, 1'b0);

    // R7 claim beats same-cycle completion
    dispatch({8'd0, 8'd50}, NR, NR, 6'd6);
    disp_valid = 1; disp_dsts = {8'd0, 8'd50}; disp_tag = 6'd8;
    cmp_valid = 1; cmp_dst = 16'd50; cmp_tag = 6'd6;
    step();
    idle();
    read_reg("R7", 16'd50, 6'd8, 1'b0);
    complete(16'd50, 6'd8, 1'b0);
    read_reg("R7", 16'd50, 6'd8, 1'b1);

    // R9 lowest slot first, once each
    dispatch({8'd0, 8'd60}, NR, NR, 6'd13);
    dispatch(16'd0, 16'd60, NR, 6'd14);
    dispatch(16'd0, 16'd60, NR, 6'd15);
    chk("R9", {31'd0, issue_valid}, 0);
    complete(16'd60, 6'd13, 1'b0);
    chk("R9", {26'd0, issue_tag}, 14);
    step();
    chk("R9", {31'd0, issue_valid}, 1);
    chk("R9", {26'd0, issue_tag}, 15);
    step();
    chk("R9", {31'd0, issue_valid}, 0);
    complete(NR, 6'd14, 1'b0);
    complete(NR, 6'd15, 1'b0);

    // R10 full queue, dropped dispatch, removal
    for (int t = 20; t < 24; t++) dispatch(16'd0, NR, NR, 6'(t));
    chk("R10", {31'd0, q_full}, 1);
    dispatch({8'd0, 8'd70}, NR, NR, 6'd30);
    read_reg("R10", 16'd70, 6'd0, 1'b1);
    complete(NR, 6'd20, 1'b0);
    chk("R10", {31'd0, q_full}, 0);
    for (int t = 21; t < 24; t++) complete(NR, 6'(t), 1'b0);

    // R11 watchdog threshold and stickiness
    chk("R11", {31'd0, stall_err}, 0);
    tick_en = 0;
    step();
    step();
    wd_fetched = wd_fetched + 1'b1;
    step();
    repeat (STALL_LIMIT - 1) step();
    chk("R11", {31'd0, stall_err}, 0);
    step();
    chk("R11", {31'd0, stall_err}, 1);
    wd_fetched = wd_fetched + 1'b1;
    step();
    chk("R11", {31'd0, stall_err}, 1);

    summary();
  end
endmodule